// File: doc/BRIEF.md
# Prioritized Edge-Triggered Interrupt Controller

The block gathers six interrupt sources for a small processor core: four external pins with selectable edge polarity, a wraparound event from a free-running timer, and a change detector over four general-purpose port inputs. Every source latches into a sticky flag. Software clears a flag only by writing a one to its bit. Each source has an enable. Every source except pin 0 has a priority bit that steers it onto either the high-priority or the low-priority request line.

The request lines are gated by a global interrupt enable. The low line is also gated by a second, low-priority global enable. A power-state input tells the block whether the core is running, idling, sleeping or in deep sleep. In idle or sleep, an enabled external pin flag raises a wake request whether or not the global enable is set. In deep sleep, all request lines are held off, and only pin 0 can restart the core, through a reset-style wake line.

Configuration uses a single write port with a 3-bit address and a 6-bit data word. The flag vector is visible directly on an output.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Pin i (0..3) sets flag bit i on a rising edge when polarity bit i (address 2, data bit i) is 1, and on a falling edge when it is 0. The flag appears after the third rising clock edge that samples the new pin level.
- R2: A flag stays set until a write to address 4 carries a one in its bit position (pins at bits 0..3, timer at bit 4, port change at bit 5). Bits written as zero are left unchanged.
- R3: When a clear of a flag and a new event for the same source fall on the same clock edge, the flag ends set.
- R4: A source whose enable bit (address 1, same bit positions as the flags) is 0 still sets its flag, but contributes to no request or wake output.
- R5: irq_hi is high exactly when the global enable (address 0, bit 0) is set, the power state is not deep sleep, and some enabled, flagged source is high priority. Pin 0 is always high priority. Address 3 data bit b selects high priority (1) for source b+1.
- R6: irq_lo is high exactly when the global enable and the low-priority enable (address 0, bit 1) are both set, the power state is not deep sleep, and some enabled, flagged source is low priority.
- R7: With address 0 bit 2 at 0, the timer flag (bit 4) is set when the low 8 bits of tmr_count go from all ones to zero between consecutive clocks. With that bit at 1, the flag is set only when all 16 bits go from all ones to zero.
- R8: Any difference in port_in between consecutive synchronized samples sets the change flag (bit 5).
- R9: In idle (pwr_state 1) or sleep (2), wake is high whenever an enabled pin flag is set, independent of the global enable. In run (0) and deep sleep (3), wake is 0.
- R10: In deep sleep (pwr_state 3), wake_reset equals flag 0, and irq_hi, irq_lo and wake are 0. Outside deep sleep, wake_reset is 0.
- R11: After reset all flags, enables and global enables are 0, every polarity bit selects rising edges, every priority bit selects high, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 4 | External interrupt pins (asynchronous) |
| port_in | input | 4 | Port inputs watched for change (asynchronous) |
| tmr_count | input | TMR_W | Current timer count, synchronous to clk |
| pwr_state | input | 2 | 0 run, 1 idle, 2 sleep, 3 deep sleep |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 control, 1 enables, 2 polarity, 3 priority, 4 flag clear |
| wr_data | input | 6 | Write data |
| flags | output | 6 | Sticky flags: pins 0..3, timer, port change |
| irq_hi | output | 1 | High-priority interrupt request |
| irq_lo | output | 1 | Low-priority interrupt request |
| wake | output | 1 | Wake from idle or sleep |
| wake_reset | output | 1 | Reset-style wake from deep sleep |

## Verification
The two functions that can collide in one cycle are a software flag clear and a hardware event that sets the same flag. The bench counts the synchronizer delay precisely, so that a clear write lands on the same edge that detects a fresh pin edge. It then judges that the flag survives; the opposite order would leave it at zero. Randomized traffic later mixes clears, reconfiguration, power-state changes and input activity. A behavioural reference model is compared against every output on every cycle, so any other coincident clear and event is also checked.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int NPIN    = 4;
    localparam int NCHG    = 4;
    localparam int SRC_TMR = NPIN;
    localparam int SRC_CHG = NPIN + 1;
    localparam int NSRC    = NPIN + 2;
    localparam int AW      = 3;
    localparam int DW      = NSRC;

    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_IDLE  = 2'd1,
        PWR_SLEEP = 2'd2,
        PWR_DEEP  = 2'd3
    } pwr_e;

    typedef enum logic [AW-1:0] {
        RA_CTRL = 3'd0,
        RA_EN   = 3'd1,
        RA_POL  = 3'd2,
        RA_PRI  = 3'd3,
        RA_CLR  = 3'd4
    } raddr_e;

    typedef struct packed {
        logic            gie;
        logic            gie_lo;
        logic            tmr_wide;
        logic [NPIN-1:0] pol;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] hipri;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        gie:      1'b0,
        gie_lo:   1'b0,
        tmr_wide: 1'b0,
        pol:      '1,
        en:       '0,
        hipri:    '1
    };

    // polarity-selected edge of one synchronized line
    function automatic logic edge_hit(input logic cur, input logic prv, input logic rise);
        return rise ? (cur & ~prv) : (~cur & prv);
    endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect import eirq_pkg::*; #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg,
    input  logic [NPIN-1:0]  pin_s,
    input  logic [NCHG-1:0]  chg_s,
    input  logic [TMR_W-1:0] tmr_count,
    output logic [NSRC-1:0]  evt
);
    localparam int HALF = TMR_W / 2;
    localparam logic [TMR_W-1:0] MASK_NARROW = {{(TMR_W-HALF){1'b0}}, {HALF{1'b1}}};

    logic [NPIN-1:0]  pin_prev;
    logic [NCHG-1:0]  chg_prev;
    logic [TMR_W-1:0] tmr_prev;
    logic [TMR_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev <= '0;
            chg_prev <= '0;
            tmr_prev <= '0;
        end else begin
            pin_prev <= pin_s;
            chg_prev <= chg_s;
            tmr_prev <= tmr_count;
        end
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign evt[g] = edge_hit(pin_s[g], pin_prev[g], cfg.pol[g]);
    end

    always_comb begin
        mask = cfg.tmr_wide ? '1 : MASK_NARROW;
        evt[SRC_TMR] = ((tmr_prev & mask) == mask) && ((tmr_count & mask) == '0);
        evt[SRC_CHG] = (chg_s != chg_prev);
    end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs import eirq_pkg::*; (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [NSRC-1:0] evt,
    output cfg_t            cfg,
    output logic [NSRC-1:0] flags
);
    logic [NSRC-1:0] clr;

    always_comb begin
        clr = '0;
        if (wr_en && raddr_e'(wr_addr) == RA_CLR) clr = wr_data[NSRC-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_RST;
            flags <= '0;
        end else begin
            // a new event overrides a simultaneous clear
            flags <= (flags & ~clr) | evt;
            if (wr_en) begin
                case (raddr_e'(wr_addr))
                    RA_CTRL: begin
                        cfg.gie      <= wr_data[0];
                        cfg.gie_lo   <= wr_data[1];
                        cfg.tmr_wide <= wr_data[2];
                    end
                    RA_EN:   cfg.en    <= wr_data[NSRC-1:0];
                    RA_POL:  cfg.pol   <= wr_data[NPIN-1:0];
                    RA_PRI:  cfg.hipri <= {wr_data[NSRC-2:0], 1'b1};
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eirq_route.sv
module eirq_route import eirq_pkg::*; (
    input  cfg_t            cfg,
    input  logic [NSRC-1:0] flags,
    input  logic [1:0]      pwr_state,
    output logic            irq_hi,
    output logic            irq_lo,
    output logic            wake,
    output logic            wake_reset
);
    logic [NSRC-1:0] pend;
    logic            deep;
    logic            doze;

    always_comb begin
        pend       = flags & cfg.en;
        deep       = (pwr_e'(pwr_state) == PWR_DEEP);
        doze       = (pwr_e'(pwr_state) == PWR_IDLE) || (pwr_e'(pwr_state) == PWR_SLEEP);
        irq_hi     = !deep && cfg.gie && (|(pend & cfg.hipri));
        irq_lo     = !deep && cfg.gie && cfg.gie_lo && (|(pend & ~cfg.hipri));
        wake       = doze && (|pend[NPIN-1:0]);
        wake_reset = deep && flags[0];
    end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl import eirq_pkg::*; #(
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPIN-1:0]  ext_pin,
    input  logic [NCHG-1:0]  port_in,
    input  logic [TMR_W-1:0] tmr_count,
    input  logic [1:0]       pwr_state,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [NSRC-1:0]  flags,
    output logic             irq_hi,
    output logic             irq_lo,
    output logic             wake,
    output logic             wake_reset
);
    localparam int SW = NPIN + NCHG;

    logic [SW-1:0]   sync_q;
    logic [NSRC-1:0] evt;
    cfg_t            cfg;

    eirq_sync #(.W(SW), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({port_in, ext_pin}),
        .q   (sync_q)
    );

    eirq_detect #(.TMR_W(TMR_W)) i_detect (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .pin_s     (sync_q[NPIN-1:0]),
        .chg_s     (sync_q[SW-1:NPIN]),
        .tmr_count (tmr_count),
        .evt       (evt)
    );

    eirq_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .evt     (evt),
        .cfg     (cfg),
        .flags   (flags)
    );

    eirq_route i_route (
        .cfg        (cfg),
        .flags      (flags),
        .pwr_state  (pwr_state),
        .irq_hi     (irq_hi),
        .irq_lo     (irq_lo),
        .wake       (wake),
        .wake_reset (wake_reset)
    );
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk import eirq_pkg::*; (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [DW-1:0]   wr_data,
    input logic [1:0]      pwr_state,
    input logic [NSRC-1:0] flags,
    input logic [NSRC-1:0] evt,
    input logic [NSRC-1:0] en,
    input logic            gie,
    input logic            gie_lo,
    input logic            irq_hi,
    input logic            irq_lo,
    input logic            wake,
    input logic            wake_reset
);
    // R2
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == RA_CLR) |=> ((flags & $past(flags)) == $past(flags)));

    // R3
    clr_race_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == RA_CLR && (|(wr_data & evt))) |=> (|(flags & $past(wr_data & evt))));

    // R4
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((flags & en) == '0) |-> !(irq_hi || irq_lo || wake));

    // R5
    hi_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_hi |-> gie);

    // R5
    pin0_high_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[0] && en[0] && gie && pwr_state != PWR_DEEP) |-> irq_hi);

    // R6
    lo_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_lo |-> (gie && gie_lo));

    // R9
    wake_state_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> (pwr_state == PWR_IDLE || pwr_state == PWR_SLEEP));

    // R10
    deep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PWR_DEEP) |-> !(irq_hi || irq_lo || wake));

    // R10
    deep_wake_chk: assert property (@(posedge clk) disable iff (rst)
        wake_reset |-> (flags[0] && pwr_state == PWR_DEEP));
endmodule

bind edge_irq_ctrl eirq_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pwr_state  (pwr_state),
    .flags      (flags),
    .evt        (evt),
    .en         (cfg.en),
    .gie        (cfg.gie),
    .gie_lo     (cfg.gie_lo),
    .irq_hi     (irq_hi),
    .irq_lo     (irq_lo),
    .wake       (wake),
    .wake_reset (wake_reset)
);

// File: tb/test_edge_irq_ctrl.sv
`timescale 1ns/100ps
module test_edge_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ext_pin = '0;
    logic [3:0]  port_in = '0;
    logic [15:0] tmr_count = '0;
    logic [1:0]  pwr_state = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [5:0]  wr_data = '0;
    logic [5:0]  flags;
    logic        irq_hi, irq_lo, wake, wake_reset;

    always #2.5 clk = ~clk;

    edge_irq_ctrl i_edge_irq_ctrl (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .port_in(port_in),
        .tmr_count(tmr_count), .pwr_state(pwr_state), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .flags(flags), .irq_hi(irq_hi),
        .irq_lo(irq_lo), .wake(wake), .wake_reset(wake_reset)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string req = "R11";
    bit    started = 0;
    bit    done = 0;

    // behavioural reference state
    logic [5:0]  m_flags, m_en, m_hip;
    logic [3:0]  m_pol;
    logic        m_gie, m_glo, m_wide;
    logic [7:0]  smp[$];
    logic [15:0] m_tprev;

    always @(posedge clk) begin
        logic [5:0]  ev, clr;
        logic [15:0] mk;
        started = 1;
        if (rst) begin
            m_flags = 0; m_en = 0; m_hip = 6'h3F; m_pol = 4'hF;
            m_gie = 0; m_glo = 0; m_wide = 0; m_tprev = 0;
            smp = {8'h00, 8'h00, 8'h00};
        end else begin
            ev = 0;
            for (int i = 0; i < 4; i++) begin
                if (m_pol[i]) ev[i] = smp[1][i] && !smp[2][i];
                else          ev[i] = !smp[1][i] && smp[2][i];
            end
            ev[5] = (smp[1][7:4] != smp[2][7:4]);
            mk = m_wide ? 16'hFFFF : 16'h00FF;
            ev[4] = ((m_tprev & mk) == mk) && ((tmr_count & mk) == 0);
            m_tprev = tmr_count;
            smp.push_front({port_in, ext_pin});
            void'(smp.pop_back());
            clr = (wr_en && wr_addr == 3'd4) ? wr_data : 6'd0;
            m_flags = (m_flags & ~clr) | ev;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_gie = wr_data[0]; m_glo = wr_data[1]; m_wide = wr_data[2]; end
                    3'd1: m_en = wr_data;
                    3'd2: m_pol = wr_data[3:0];
                    3'd3: m_hip = {wr_data[4:0], 1'b1};
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison away from both edges
    always @(negedge clk) begin
        logic [5:0] pend;
        logic deep, doze;
        #1;
        if (started && !done) begin
            pend = m_flags & m_en;
            deep = (pwr_state == 2'd3);
            doze = (pwr_state == 2'd1) || (pwr_state == 2'd2);
            chk("flags", 16'(flags), 16'(m_flags));
            chk("irq_hi", 16'(irq_hi), 16'(!deep && m_gie && (|(pend & m_hip))));
            chk("irq_lo", 16'(irq_lo), 16'(!deep && m_gie && m_glo && (|(pend & ~m_hip))));
            chk("wake", 16'(wake), 16'(doze && (|pend[3:0])));
            chk("wake_reset", 16'(wake_reset), 16'(deep && m_flags[0]));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [5:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic see(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        string keep;
        keep = req; req = tag;
        chk(what, act, exp);
        req = keep;
    endtask

    task automatic summary;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R11: reset state
        req = "R11";
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        see("R11", "flags after reset", 16'(flags), 16'h0);
        see("R11", "outputs after reset", 16'({irq_hi, irq_lo, wake, wake_reset}), 16'h0);

        // R1: polarity
        req = "R1";
        @(negedge clk); ext_pin[0] = 1; idle(3); #1;
        see("R1", "pin0 rising flag", 16'(flags[0]), 16'h1);
        wr(3'd2, 6'b1101);
        @(negedge clk); ext_pin[1] = 1; idle(4); #1;
        see("R1", "pin1 rising ignored when falling selected", 16'(flags[1]), 16'h0);
        @(negedge clk); ext_pin[1] = 0; idle(4); #1;
        see("R1", "pin1 falling flag", 16'(flags[1]), 16'h1);

        // R2: write-one-to-clear
        req = "R2";
        wr(3'd4, 6'b000001); #1;
        see("R2", "pin0 cleared, pin1 kept", 16'(flags[1:0]), 16'h2);
        idle(5); #1;
        see("R2", "pin1 still sticky", 16'(flags[1]), 16'h1);

        // R3: clear and new event on the same edge
        req = "R3";
        @(negedge clk); ext_pin[2] = 1; idle(4);
        wr(3'd4, 6'b000100);
        @(negedge clk); ext_pin[2] = 0; idle(4);
        @(negedge clk); ext_pin[2] = 1;
        @(negedge clk);
        @(negedge clk); wr_en = 1; wr_addr = 3'd4; wr_data = 6'b000100;
        @(negedge clk); wr_en = 0; #1;
        see("R3", "event beats clear", 16'(flags[2]), 16'h1);

        // R4: disabled sources latch but stay silent
        req = "R4";
        wr(3'd0, 6'b000011); idle(1); #1;
        see("R4", "no request with enables off", 16'({irq_hi, irq_lo}), 16'h0);
        see("R4", "flags still visible", 16'(flags[2:1]), 16'h3);

        // R5: routing, pin0 fixed high
        req = "R5";
        wr(3'd3, 6'b000000);
        wr(3'd1, 6'b000001);
        @(negedge clk); ext_pin[0] = 0; idle(4); ext_pin[0] = 1; idle(4); #1;
        see("R5", "pin0 high with all priority low", 16'({irq_hi, irq_lo}), 16'h2);
        wr(3'd4, 6'b000001);
        wr(3'd3, 6'b000010); wr(3'd1, 6'b000100); #1;
        see("R5", "pin2 routed high", 16'({irq_hi, irq_lo}), 16'h2);

        // R6: low line and its enable
        req = "R6";
        wr(3'd1, 6'b000010); #1;
        see("R6", "pin1 routed low", 16'({irq_hi, irq_lo}), 16'h1);
        wr(3'd0, 6'b000001); #1;
        see("R6", "low enable off", 16'(irq_lo), 16'h0);
        wr(3'd4, 6'b111111);

        // R7: timer wrap widths
        req = "R7";
        @(negedge clk); tmr_count = 16'h00FE;
        @(negedge clk); tmr_count = 16'h00FF;
        @(negedge clk); tmr_count = 16'h0100;
        @(negedge clk); #1;
        see("R7", "narrow wrap", 16'(flags[4]), 16'h1);
        wr(3'd4, 6'b010000);
        wr(3'd0, 6'b000101);
        @(negedge clk); tmr_count = 16'h01FF;
        @(negedge clk); tmr_count = 16'h0200;
        @(negedge clk); #1;
        see("R7", "low byte wrap ignored when wide", 16'(flags[4]), 16'h0);
        @(negedge clk); tmr_count = 16'hFFFF;
        @(negedge clk); tmr_count = 16'h0000;
        @(negedge clk); #1;
        see("R7", "wide wrap", 16'(flags[4]), 16'h1);

        // R8: port change
        req = "R8";
        @(negedge clk); port_in[3] = 1; idle(4); #1;
        see("R8", "change flag", 16'(flags[5]), 16'h1);

        // R9: wake from sleep without global enable
        req = "R9";
        wr(3'd4, 6'b111111);
        wr(3'd0, 6'b000000);
        wr(3'd1, 6'b001000);
        @(negedge clk); pwr_state = 2'd2; ext_pin[3] = 1; idle(4); #1;
        see("R9", "wake in sleep", 16'(wake), 16'h1);
        see("R9", "no vectored request", 16'(irq_hi), 16'h0);
        @(negedge clk); pwr_state = 2'd0; #1;
        see("R9", "no wake while running", 16'(wake), 16'h0);

        // R10: deep sleep restart from pin 0 only
        req = "R10";
        wr(3'd4, 6'b111111);
        wr(3'd0, 6'b000011); wr(3'd1, 6'b111111);
        @(negedge clk); pwr_state = 2'd3; ext_pin[1] = 1; ext_pin[0] = 0; idle(4); #1;
        see("R10", "pin1 does not restart", 16'(wake_reset), 16'h0);
        @(negedge clk); ext_pin[0] = 1; idle(4); #1;
        see("R10", "pin0 restart", 16'(wake_reset), 16'h1);
        see("R10", "requests off in deep", 16'({irq_hi, irq_lo, wake}), 16'h0);

        // mixed traffic, compared every cycle against the model (R1..R10)
        req = "R5";
        tmr_count = 16'hFF00;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if ($urandom_range(0, 5) == 0) ext_pin = 4'($urandom);
            if ($urandom_range(0, 7) == 0) port_in = 4'($urandom);
            if ($urandom_range(0, 15) == 0) pwr_state = 2'($urandom);
            tmr_count = tmr_count + 16'd1;
            wr_en = ($urandom_range(0, 3) == 0);
            wr_addr = 3'($urandom_range(0, 5));
            wr_data = 6'($urandom);
        end
        @(negedge clk); wr_en = 0;
        idle(4);
        summary();
    end
endmodule